// File: doc/BRIEF.md
# Tamper Supervisor Security State Machine

This block decides whether a battery-backed security domain is trusted. It keeps two state flags. The non-valid flag is raised by a battery-domain reset. The violation flag is raised when an armed security event arrives. The domain is valid only when both flags are low. Ten event inputs (voltage, clock, temperature, secure-controller alarm, external boot, external tamper A and B, wire mesh, time-counter overflow, monotonic-counter overflow) are latched into sticky status bits whether or not they are armed. Only an armed event trips the violation flag. While the domain is not valid, a stop signal freezes the counters that sit beside the block.

Software drives the block through a single-cycle register write port with four targets: the event arm mask, the lock controls, the write-1-to-clear status word, and the interrupt enable. A violation on its own (the violation flag set, the non-valid flag clear) locks the block completely. A system reset moves it into non-valid plus violation, unless a failure hard lock is set. From that state, recovery must follow a fixed order: disarm the events, clear the event flags, clear the violation flag, then clear the non-valid flag. The port carries no data stream, so it has no valid/ready handshake. Every write completes in the cycle it is presented.

Top module: `tamper_supervisor`

## Requirements
- R1: When the battery reset is asserted, the status word becomes 0x00000002 (non-valid only). The interrupt goes low, the counter stop goes high, and the arm mask, all locks and the interrupt enable are cleared.
- R2: A pulse on event input i sets its sticky status bit, whether or not the event is armed. The positions are: inputs 0..7 map to status bits 16..23, input 8 maps to bit 2, and input 9 maps to bit 3. The bit is visible after the next clock edge.
- R3: An event pulse whose arm bit (arm mask bit i, written with select 0) is set raises the violation flag, status bit 0, after the next clock edge. An unarmed event leaves the flag unchanged.
- R4: While the violation flag is set and the non-valid flag is clear, writes to the arm mask, the control word and the status word have no effect.
- R5: A system reset pulse in that locked state sets the non-valid flag (status bit 1) and keeps the violation flag. If the failure hard lock (control bit 16) is set, the pulse changes nothing.
- R6: Writes to the arm mask are ignored while the configuration soft lock (control bit 29) or hard lock (control bit 30) is set. Lock bits are set by writing 1 and are never cleared by a write. A system reset clears only the soft lock. A battery reset clears both.
- R7: Writing 1 to status bit 0 (select 2) clears the violation flag only when the non-valid flag is set and no armed event flag remains set.
- R8: Writing 1 to status bit 1 clears the non-valid flag only when the violation flag is clear. Clearing it returns the block to the valid state.
- R9: Event status bits clear when 1 is written to their position. A new pulse in the same cycle wins over the clear.
- R10: The interrupt output equals the violation flag ANDed with interrupt enable bit 0 (select 3). The enable is writable in every state.
- R11: The counter stop output is high whenever the violation flag or the non-valid flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| batt_rst_n | input | 1 | Battery-domain reset, asynchronous, active low |
| sys_rst_req | input | 1 | System reset pulse, synchronous, active high |
| evt_pulse | input | NUM_EVT | Event pulses, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 arm mask, 1 control, 2 status clear, 3 interrupt enable |
| wr_data | input | DW | Write data |
| status_o | output | DW | Status word |
| irq_o | output | 1 | Violation interrupt |
| cnt_stop_o | output | 1 | Stop request to the neighbouring counters |

## Verification
The bench builds the block with its default parameters: ten event sources and a 32-bit data word. These values place every event bit at the position the status decoder expects, and they expose all three lock bits. The whole recovery path is driven, including out-of-order attempts that must be refused. Locks are proven through their effect at the ports: an arm write that was refused shows up as an event that still trips, and a hard lock shows up as a system reset with no effect.

// File: rtl/tsup_pkg.sv
package tsup_pkg;
  localparam int ST_SVF      = 0;
  localparam int ST_NV       = 1;
  localparam int CTL_FAIL_HL = 16;
  localparam int CTL_CFG_SL  = 29;
  localparam int CTL_CFG_HL  = 30;

  typedef enum logic [1:0] {
    SEL_ARM  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_IRQ  = 2'd3
  } wsel_e;

  // status position of event source i
  function automatic int evt_pos(input int i);
    if (i < 8) return 16 + i;
    else if (i == 8) return 2;
    else return 3;
  endfunction
endpackage

// File: rtl/tsup_event_bank.sv
module tsup_event_bank #(
  parameter int NUM_EVT = 10
) (
  input  logic               clk,
  input  logic               batt_rst_n,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [NUM_EVT-1:0] clr_mask,
  output logic [NUM_EVT-1:0] flags
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    always_ff @(posedge clk or negedge batt_rst_n) begin
      if (!batt_rst_n)       flags[i] <= 1'b0;
      else if (evt_pulse[i]) flags[i] <= 1'b1;
      else if (clr_mask[i])  flags[i] <= 1'b0;
    end

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!batt_rst_n)
      (flags[i] && !clr_mask[i]) |=> flags[i]);
    assert_flag_sets_R2: assert property (@(posedge clk) disable iff (!batt_rst_n)
      evt_pulse[i] |=> flags[i]);
  end
endmodule

// File: rtl/tsup_lock_regs.sv
module tsup_lock_regs #(
  parameter int NUM_EVT = 10
) (
  input  logic               clk,
  input  logic               batt_rst_n,
  input  logic               sys_rst_req,
  input  logic               arm_wr,
  input  logic [NUM_EVT-1:0] arm_data,
  input  logic               ctrl_wr,
  input  logic               set_fail_hl,
  input  logic               set_cfg_sl,
  input  logic               set_cfg_hl,
  output logic [NUM_EVT-1:0] arm,
  output logic               fail_hl,
  output logic               cfg_sl,
  output logic               cfg_hl
);
  logic cfg_locked;
  assign cfg_locked = cfg_sl | cfg_hl;

  always_ff @(posedge clk or negedge batt_rst_n) begin
    if (!batt_rst_n) begin
      arm     <= '0;
      fail_hl <= 1'b0;
      cfg_sl  <= 1'b0;
      cfg_hl  <= 1'b0;
    end else begin
      if (arm_wr && !cfg_locked) arm <= arm_data;
      if (ctrl_wr && set_fail_hl) fail_hl <= 1'b1;
      if (ctrl_wr && set_cfg_hl)  cfg_hl  <= 1'b1;
      if (sys_rst_req)            cfg_sl  <= 1'b0;
      else if (ctrl_wr && set_cfg_sl) cfg_sl <= 1'b1;
    end
  end

  assert_hard_lock_kept_R6: assert property (@(posedge clk) disable iff (!batt_rst_n)
    cfg_hl |=> cfg_hl);
  assert_arm_frozen_R6: assert property (@(posedge clk) disable iff (!batt_rst_n)
    cfg_locked |=> $stable(arm));
endmodule

// File: rtl/tsup_state_core.sv
module tsup_state_core (
  input  logic clk,
  input  logic batt_rst_n,
  input  logic sys_rst_req,
  input  logic trip,
  input  logic armed_any,
  input  logic fail_hl,
  input  logic svf_clr_req,
  input  logic nv_clr_req,
  output logic svf,
  output logic nv
);
  always_ff @(posedge clk or negedge batt_rst_n) begin
    if (!batt_rst_n) begin
      svf <= 1'b0;
      nv  <= 1'b1;
    end else begin
      if (trip) svf <= 1'b1;
      else if (svf_clr_req && nv && !armed_any) svf <= 1'b0;

      if (sys_rst_req && svf && !nv && !fail_hl) nv <= 1'b1;
      else if (nv_clr_req && !svf) nv <= 1'b0;
    end
  end

  assert_trip_fails_R3: assert property (@(posedge clk) disable iff (!batt_rst_n)
    trip |=> svf);
  assert_fail_only_held_R7: assert property (@(posedge clk) disable iff (!batt_rst_n)
    (svf && !nv) |=> svf);
  assert_nv_held_in_fail_R8: assert property (@(posedge clk) disable iff (!batt_rst_n)
    (svf && nv) |=> nv);
endmodule

// File: rtl/tamper_supervisor.sv
module tamper_supervisor #(
  parameter int NUM_EVT = 10,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               batt_rst_n,
  input  logic               sys_rst_req,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      status_o,
  output logic               irq_o,
  output logic               cnt_stop_o
);
  import tsup_pkg::*;

  logic               svf, nv, fail_only, allow;
  logic               arm_wr, ctrl_wr, stat_wr;
  logic               fail_hl, cfg_sl, cfg_hl, irq_en;
  logic [NUM_EVT-1:0] arm, flags, clr_mask;

  assign fail_only = svf & ~nv;
  assign allow     = ~fail_only & ~sys_rst_req;
  assign arm_wr    = wr_en && (wr_sel == SEL_ARM)  && allow;
  assign ctrl_wr   = wr_en && (wr_sel == SEL_CTRL) && allow;
  assign stat_wr   = wr_en && (wr_sel == SEL_STAT) && allow;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_clr
    assign clr_mask[i] = stat_wr & wr_data[evt_pos(i)];
  end

  tsup_event_bank #(.NUM_EVT(NUM_EVT)) u_events (
    .clk(clk), .batt_rst_n(batt_rst_n), .evt_pulse(evt_pulse),
    .clr_mask(clr_mask), .flags(flags)
  );

  tsup_lock_regs #(.NUM_EVT(NUM_EVT)) u_locks (
    .clk(clk), .batt_rst_n(batt_rst_n), .sys_rst_req(sys_rst_req),
    .arm_wr(arm_wr), .arm_data(wr_data[NUM_EVT-1:0]), .ctrl_wr(ctrl_wr),
    .set_fail_hl(wr_data[CTL_FAIL_HL]), .set_cfg_sl(wr_data[CTL_CFG_SL]),
    .set_cfg_hl(wr_data[CTL_CFG_HL]),
    .arm(arm), .fail_hl(fail_hl), .cfg_sl(cfg_sl), .cfg_hl(cfg_hl)
  );

  tsup_state_core u_core (
    .clk(clk), .batt_rst_n(batt_rst_n), .sys_rst_req(sys_rst_req),
    .trip(|(evt_pulse & arm)), .armed_any(|(flags & arm)), .fail_hl(fail_hl),
    .svf_clr_req(stat_wr & wr_data[ST_SVF]), .nv_clr_req(stat_wr & wr_data[ST_NV]),
    .svf(svf), .nv(nv)
  );

  always_ff @(posedge clk or negedge batt_rst_n) begin
    if (!batt_rst_n) irq_en <= 1'b0;
    else if (wr_en && wr_sel == SEL_IRQ) irq_en <= wr_data[0];
  end

  always_comb begin
    status_o         = '0;
    status_o[ST_SVF] = svf;
    status_o[ST_NV]  = nv;
    for (int i = 0; i < NUM_EVT; i++) status_o[evt_pos(i)] = flags[i];
  end

  assign irq_o      = svf & irq_en;
  assign cnt_stop_o = svf | nv;

  assert_locked_writes_R4: assert property (@(posedge clk) disable iff (!batt_rst_n)
    (fail_only && !sys_rst_req && evt_pulse == '0) |=> $stable(status_o));
  assert_stop_in_fail_R11: assert property (@(posedge clk) disable iff (!batt_rst_n)
    $rose(svf) |-> cnt_stop_o);
endmodule

// File: tb/tamper_supervisor_test.sv
module tamper_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 10;

  logic          clk = 1'b0;
  logic          batt_rst_n = 1'b0;
  logic          sys_rst_req = 1'b0;
  logic [NE-1:0] evt_pulse = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   status_o;
  logic          irq_o, cnt_stop_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tamper_supervisor uut (
    .clk(clk), .batt_rst_n(batt_rst_n), .sys_rst_req(sys_rst_req),
    .evt_pulse(evt_pulse), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .status_o(status_o), .irq_o(irq_o), .cnt_stop_o(cnt_stop_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [NE-1:0] m);
    @(negedge clk); evt_pulse = m;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic sysrst();
    @(negedge clk); sys_rst_req = 1'b1;
    @(negedge clk); sys_rst_req = 1'b0;
  endtask

  task automatic battrst();
    @(negedge clk); batt_rst_n = 1'b0;
    @(negedge clk); batt_rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    battrst();
    check("R1 status", status_o, 32'h2);
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R11 stop after reset", {31'b0, cnt_stop_o}, 1);
    wr(2'd2, 32'h2);
    check("R8 nv cleared to valid", status_o, 0);
    check("R11 stop low when valid", {31'b0, cnt_stop_o}, 0);
  endtask

  task automatic t_flags();
    pulse(10'h001); check("R2 voltage bit16 unarmed", status_o, 32'h0001_0000);
    pulse(10'h100); check("R2 time ovf bit2", status_o, 32'h0001_0004);
    pulse(10'h200); check("R2 mono ovf bit3", status_o, 32'h0001_000C);
    pulse(10'h080); check("R3 unarmed no trip, mesh bit23", status_o, 32'h0081_000C);
    wr(2'd2, 32'h0081_000C); check("R9 w1c flags", status_o, 0);
    @(negedge clk); evt_pulse = 10'h002; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'h0002_0000;
    @(negedge clk); evt_pulse = '0; wr_en = 1'b0; wr_data = '0;
    check("R9 pulse wins over clear", status_o, 32'h0002_0000);
    wr(2'd2, 32'h0002_0000);
  endtask

  task automatic t_trip_recover();
    wr(2'd3, 1); wr(2'd0, 32'h004);
    pulse(10'h004);
    check("R3 armed temp trips", status_o, 32'h0004_0001);
    check("R10 irq on", {31'b0, irq_o}, 1);
    wr(2'd2, 32'hFFFF_FFFF); check("R4 status write ignored", status_o, 32'h0004_0001);
    wr(2'd1, 32'h0001_0000);
    sysrst(); check("R5 sysrst to nv+fail", status_o, 32'h0004_0003);
    wr(2'd2, 32'h1); check("R7 svf kept while armed flag", status_o, 32'h0004_0003);
    wr(2'd2, 32'h2); check("R8 nv kept while svf", status_o, 32'h0004_0003);
    wr(2'd0, 0); wr(2'd2, 32'h0004_0000);
    wr(2'd2, 32'h1); check("R7 svf cleared in order", status_o, 32'h2);
    check("R10 irq off", {31'b0, irq_o}, 0);
    wr(2'd2, 32'h2); check("R8 back to valid", status_o, 0);
  endtask

  task automatic t_soft_lock();
    wr(2'd0, 32'h001); wr(2'd1, 32'h2000_0000); wr(2'd0, 0);
    pulse(10'h001); check("R6 soft lock kept arm", status_o, 32'h0001_0001);
    sysrst(); wr(2'd0, 0); wr(2'd2, 32'h0001_0000); wr(2'd2, 1); wr(2'd2, 2);
    check("R6 recovered", status_o, 0);
    pulse(10'h001); check("R6 soft lock gone after sysrst", status_o, 32'h0001_0000);
    wr(2'd2, 32'h0001_0000);
  endtask

  task automatic t_hard_lock();
    wr(2'd0, 32'h020); wr(2'd1, 32'h4000_0000);
    sysrst(); check("R5 sysrst in valid no change", status_o, 0);
    wr(2'd0, 0);
    pulse(10'h020); check("R6 hard lock survives sysrst", status_o, 32'h0020_0001);
    battrst(); check("R1 battery reset", status_o, 32'h2);
    wr(2'd2, 2); wr(2'd0, 0);
    pulse(10'h020); check("R6 hard lock cleared by battery", status_o, 32'h0020_0000);
    wr(2'd2, 32'h0020_0000);
  endtask

  task automatic t_fail_hl();
    wr(2'd0, 32'h080); wr(2'd1, 32'h0001_0000); wr(2'd3, 1);
    pulse(10'h080); check("R3 mesh trips", status_o, 32'h0080_0001);
    check("R10 irq", {31'b0, irq_o}, 1);
    wr(2'd3, 0); check("R10 irq masked", {31'b0, irq_o}, 0);
    sysrst(); check("R5 fail hard lock blocks sysrst", status_o, 32'h0080_0001);
    check("R11 stop in failure", {31'b0, cnt_stop_o}, 1);
    battrst(); check("R1 battery escapes", status_o, 32'h2);
  endtask

  initial begin
    t_reset();
    t_flags();
    t_trip_recover();
    t_soft_lock();
    t_hard_lock();
    t_fail_hl();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule